// File: doc/BRIEF.md
# Peripheral Pin Remapping Crossbar

This block sits between a group of digital peripherals and a bank of up to sixteen general-purpose pads, so that software can choose which pad each peripheral uses. Each peripheral input has its own select register. The register holds a pin number, and the peripheral sees that pad's input value. Each pad has its own output function register. The register holds a function code, and the pad is driven by that peripheral output's data and enable. The two sets of registers are separate, so the input and output of one peripheral can be placed on unrelated pins.

No remappable peripheral has a default pin. After reset every peripheral input reads the idle level 1, and every pad carries its ordinary port function. On each pad an enabled analog function has the highest priority. A remapped output comes next, and the port function comes last. The mapping registers are guarded by a write lock. A two-step key sequence opens the lock for exactly one bus access.

The bus is write-only and takes one access per clock cycle. Addresses 0 to NUM_IN-1 hold the input selects. Addresses 16+p hold the output code of pin p. Address 63 is the key register.

Top module: `pin_remap_xbar`

## Requirements
- R1: After reset every input select holds 31 (unassigned), so every periph_in_o bit is 1. Every output code is 0, so pin_out_o/pin_oe_o equal port_out_i/port_oe_i.
- R2: A mapping write to address k (k < NUM_IN) stores wdata[4:0] as the select of peripheral input k. A value n below NUM_PINS makes periph_in_o[k] follow pad_in_i[n].
- R3: An input select value from NUM_PINS to 31 drives that peripheral input to a constant 1, whatever the pads do.
- R4: A mapping write to address 16+p stores wdata[4:0] as the output code of pin p. A code c from 1 to NUM_OUT_FN drives pin_out_o[p] from fn_out_i[c-1] and pin_oe_o[p] from fn_oe_i[c-1], overriding the port function.
- R5: Output code 0, or any code above NUM_OUT_FN, leaves pin p on port_out_i[p]/port_oe_i[p].
- R6: While ana_en_i[p] is 1, pin_out_o[p] and pin_oe_o[p] are both 0, whatever code pin p holds.
- R7: The lock is set after reset. A mapping write made while the lock is set changes no mapping.
- R8: The lock clears only after two accesses to address 63 on consecutive clock cycles, the first with data 0xA5 and the second with 0x5A. An idle cycle between them, or any other second value, leaves the lock set.
- R9: Once unlocked, the next bus access is accepted if it is a mapping write, and the lock is set again whatever that access was. A second mapping write is ignored.
- R10: An accepted write changes the outputs right after the clock edge that takes it. Input and output maps are independent, so one pad can drive several peripheral inputs while it also carries a remapped output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus write access this cycle |
| bus_addr_i | input | 6 | Register address |
| bus_wdata_i | input | 8 | Write data (mapping value in bits 4:0) |
| pad_in_i | input | NUM_PINS | Input value from each pad |
| port_out_i | input | NUM_PINS | Default port output value per pin |
| port_oe_i | input | NUM_PINS | Default port output enable per pin |
| ana_en_i | input | NUM_PINS | Analog function enabled per pin |
| fn_out_i | input | NUM_OUT_FN | Remappable peripheral output data, one per function code 1..NUM_OUT_FN |
| fn_oe_i | input | NUM_OUT_FN | Remappable peripheral output enables |
| periph_in_o | output | NUM_IN | Routed value for each remappable peripheral input |
| pin_out_o | output | NUM_PINS | Output value to each pad |
| pin_oe_o | output | NUM_PINS | Output enable to each pad |

## Verification
Some rules are checked by assertions on every cycle. Mapping registers stay stable in any cycle without an accepted write. The lock only clears right after the first key step. Any access made while unlocked re-arms the lock. An enabled analog function silences its pad, and an out-of-range input select reads 1. The bench scenarios are needed for the rest. They show the routing values themselves, the exact key order and its failure cases, the one-shot behaviour of the lock, the valid/invalid boundary at pin 15 and code 8, and the fact that one pad can serve input and output maps at once.

// File: rtl/pin_remap_pkg.sv
package pin_remap_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 5;
  localparam int SEL_N  = 1 << SEL_W;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam sel_t SEL_UNASSIGNED = '1;
  localparam sel_t CODE_PORT      = '0;

  typedef struct packed {
    logic  valid;
    addr_t addr;
    data_t wdata;
  } bus_req_t;
endpackage

// File: rtl/remap_key_lock.sv
module remap_key_lock
  import pin_remap_pkg::*;
#(
  parameter addr_t KEY_ADDR = 6'd63,
  parameter data_t KEY_A    = 8'hA5,
  parameter data_t KEY_B    = 8'h5A
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bus_req_t req_i,
  output logic     wr_ok_o
);
  logic lock_q, half_q;
  logic key_hit_a, key_hit_b;

  assign key_hit_a = req_i.valid && (req_i.addr == KEY_ADDR) && (req_i.wdata == KEY_A);
  assign key_hit_b = req_i.valid && (req_i.addr == KEY_ADDR) && (req_i.wdata == KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
      half_q <= 1'b0;
    end else begin
      // first key step only survives one cycle
      half_q <= key_hit_a;
      if (half_q && key_hit_b) lock_q <= 1'b0;
      else if (req_i.valid)    lock_q <= 1'b1;
    end
  end

  assign wr_ok_o = req_i.valid && !lock_q && (req_i.addr != KEY_ADDR);

  p_unlock_key_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(half_q));

  p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i.valid && !lock_q) |=> lock_q);
endmodule

// File: rtl/remap_regs.sv
module remap_regs
  import pin_remap_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_PINS = 16,
  parameter int IN_BASE  = 0,
  parameter int OUT_BASE = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  addr_t                      addr_i,
  input  sel_t                       data_i,
  output logic [NUM_IN-1:0][SEL_W-1:0]   in_sel_o,
  output logic [NUM_PINS-1:0][SEL_W-1:0] out_code_o
);
  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    localparam addr_t ADDR = addr_t'(IN_BASE + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        in_sel_o[k] <= SEL_UNASSIGNED;
      else if (wr_i && addr_i == ADDR)    in_sel_o[k] <= data_i;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_out
    localparam addr_t ADDR = addr_t'(OUT_BASE + p);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        out_code_o[p] <= CODE_PORT;
      else if (wr_i && addr_i == ADDR)    out_code_o[p] <= data_i;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(in_sel_o) && $stable(out_code_o)));
endmodule

// File: rtl/remap_in_route.sv
module remap_in_route
  import pin_remap_pkg::*;
#(
  parameter int NUM_IN   = 8,
  parameter int NUM_PINS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_IN-1:0][SEL_W-1:0]  in_sel_i,
  input  logic [NUM_PINS-1:0]           pad_in_i,
  output logic [NUM_IN-1:0]             periph_in_o
);
  // pads above NUM_PINS read as idle 1
  logic [SEL_N-1:0] pad_ext;
  assign pad_ext = {{(SEL_N-NUM_PINS){1'b1}}, pad_in_i};

  for (genvar k = 0; k < NUM_IN; k++) begin : g_route
    assign periph_in_o[k] = pad_ext[in_sel_i[k]];

    p_invalid_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(in_sel_i[k]) >= NUM_PINS) |-> periph_in_o[k]);
  end
endmodule

// File: rtl/remap_pin_out.sv
module remap_pin_out
  import pin_remap_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int NUM_OUT_FN = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_PINS-1:0][SEL_W-1:0]  out_code_i,
  input  logic [NUM_PINS-1:0]             port_out_i,
  input  logic [NUM_PINS-1:0]             port_oe_i,
  input  logic [NUM_PINS-1:0]             ana_en_i,
  input  logic [NUM_OUT_FN-1:0]           fn_out_i,
  input  logic [NUM_OUT_FN-1:0]           fn_oe_i,
  output logic [NUM_PINS-1:0]             pin_out_o,
  output logic [NUM_PINS-1:0]             pin_oe_o
);
  localparam int PAD_W = SEL_N - 1 - NUM_OUT_FN;

  // code 0 and codes above NUM_OUT_FN are not remap hits
  logic [SEL_N-1:0] hit_ext, dat_ext, oe_ext;
  assign hit_ext = {{PAD_W{1'b0}}, {NUM_OUT_FN{1'b1}}, 1'b0};
  assign dat_ext = {{PAD_W{1'b0}}, fn_out_i, 1'b0};
  assign oe_ext  = {{PAD_W{1'b0}}, fn_oe_i, 1'b0};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic remap_hit;
    assign remap_hit = hit_ext[out_code_i[p]];

    always_comb begin
      if (ana_en_i[p]) begin
        pin_out_o[p] = 1'b0;
        pin_oe_o[p]  = 1'b0;
      end else if (remap_hit) begin
        pin_out_o[p] = dat_ext[out_code_i[p]];
        pin_oe_o[p]  = oe_ext[out_code_i[p]];
      end else begin
        pin_out_o[p] = port_out_i[p];
        pin_oe_o[p]  = port_oe_i[p];
      end
    end

    p_analog_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ana_en_i[p] |-> (!pin_oe_o[p] && !pin_out_o[p]));
  end
endmodule

// File: rtl/pin_remap_xbar.sv
module pin_remap_xbar
  import pin_remap_pkg::*;
#(
  parameter int    NUM_PINS   = 16,
  parameter int    NUM_IN     = 8,
  parameter int    NUM_OUT_FN = 8,
  parameter int    IN_BASE    = 0,
  parameter int    OUT_BASE   = 16,
  parameter addr_t KEY_ADDR   = 6'd63,
  parameter data_t KEY_A      = 8'hA5,
  parameter data_t KEY_B      = 8'h5A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_valid_i,
  input  logic [5:0]            bus_addr_i,
  input  logic [7:0]            bus_wdata_i,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  input  logic [NUM_PINS-1:0]   port_out_i,
  input  logic [NUM_PINS-1:0]   port_oe_i,
  input  logic [NUM_PINS-1:0]   ana_en_i,
  input  logic [NUM_OUT_FN-1:0] fn_out_i,
  input  logic [NUM_OUT_FN-1:0] fn_oe_i,
  output logic [NUM_IN-1:0]     periph_in_o,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [NUM_PINS-1:0]   pin_oe_o
);
  initial begin
    if (NUM_PINS < 1 || NUM_PINS > 16) $error("NUM_PINS out of range");
    if (NUM_OUT_FN < 1 || NUM_OUT_FN > 30) $error("NUM_OUT_FN out of range");
  end

  bus_req_t req;
  logic     wr_ok;
  logic [NUM_IN-1:0][SEL_W-1:0]   in_sel;
  logic [NUM_PINS-1:0][SEL_W-1:0] out_code;

  assign req = '{valid: bus_valid_i, addr: bus_addr_i, wdata: bus_wdata_i};

  remap_key_lock #(.KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_lock (
    .clk_i, .rst_ni, .req_i(req), .wr_ok_o(wr_ok)
  );

  remap_regs #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS), .IN_BASE(IN_BASE),
               .OUT_BASE(OUT_BASE)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr_ok), .addr_i(req.addr),
    .data_i(req.wdata[SEL_W-1:0]), .in_sel_o(in_sel), .out_code_o(out_code)
  );

  remap_in_route #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS)) u_in (
    .clk_i, .rst_ni, .in_sel_i(in_sel), .pad_in_i, .periph_in_o
  );

  remap_pin_out #(.NUM_PINS(NUM_PINS), .NUM_OUT_FN(NUM_OUT_FN)) u_out (
    .clk_i, .rst_ni, .out_code_i(out_code), .port_out_i, .port_oe_i,
    .ana_en_i, .fn_out_i, .fn_oe_i, .pin_out_o, .pin_oe_o
  );
endmodule

// File: tb/pin_remap_xbar_tb.sv
module pin_remap_xbar_tb;
  localparam int NP = 16, NI = 8, NF = 8;
  localparam logic [15:0] PORT_OUT = 16'h3C5A;
  localparam logic [15:0] PORT_OE  = 16'h0F0F;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [NP-1:0] pads = '0, port_out = PORT_OUT, port_oe = PORT_OE, ana = '0;
  logic [NF-1:0] fn_out = '0, fn_oe = '0;
  logic [NI-1:0] periph_in;
  logic [NP-1:0] pin_out, pin_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  pin_remap_xbar u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .pad_in_i(pads), .port_out_i(port_out),
    .port_oe_i(port_oe), .ana_en_i(ana), .fn_out_i(fn_out), .fn_oe_i(fn_oe),
    .periph_in_o(periph_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic unlock();
    bus_valid = 1'b1; bus_addr = 6'd63; bus_wdata = 8'hA5;
    @(posedge clk); @(negedge clk);
    bus_wdata = 8'h5A;
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic map_wr(input logic [5:0] a, input logic [7:0] d);
    unlock();
    wr(a, d);
  endtask

  task automatic t_reset();
    pads = '0; #1;
    chk("R1 inputs idle", periph_in, 8'hFF);
    chk("R1 pin out port", pin_out, PORT_OUT);
    chk("R1 pin oe port", pin_oe, PORT_OE);
  endtask

  task automatic t_locked();
    fn_out = '1; fn_oe = '1; pads = '0;
    wr(6'd0, 8'd3);
    wr(6'd20, 8'd2);
    #1;
    chk("R7 locked input write", periph_in[0], 1'b1);
    chk("R7 locked output write", pin_oe[4], PORT_OE[4]);
    fn_out = '0; fn_oe = '0;
  endtask

  task automatic t_in_route();
    map_wr(6'd0, 8'd3);
    pads = 16'hFFF7; #1;
    chk("R2 pad3 low", periph_in[0], 1'b0);
    pads = 16'h0008; #1;
    chk("R2 pad3 high", periph_in[0], 1'b1);
    map_wr(6'd5, 8'd15);
    pads = 16'h8000; #1;
    chk("R2 pad15 high", periph_in[5], 1'b1);
    chk("R2 input0 still pad3", periph_in[0], 1'b0);
    pads = 16'h7FFF; #1;
    chk("R2 pad15 low", periph_in[5], 1'b0);
  endtask

  task automatic t_one_shot();
    pads = '0;
    unlock();
    wr(6'd1, 8'd4);
    wr(6'd2, 8'd4);
    #1;
    chk("R9 first write taken", periph_in[1], 1'b0);
    chk("R9 second write dropped", periph_in[2], 1'b1);
  endtask

  task automatic t_bad_key();
    pads = '0;
    wr(6'd63, 8'hA5);
    @(negedge clk);
    wr(6'd63, 8'h5A);
    wr(6'd3, 8'd0); #1;
    chk("R8 gap between keys", periph_in[3], 1'b1);
    wr(6'd63, 8'hA5);
    wr(6'd63, 8'h5B);
    wr(6'd3, 8'd0); #1;
    chk("R8 wrong second key", periph_in[3], 1'b1);
    unlock();
    wr(6'd3, 8'd0); #1;
    chk("R8 correct keys", periph_in[3], 1'b0);
  endtask

  task automatic t_invalid();
    pads = '0;
    map_wr(6'd0, 8'd16); #1;
    chk("R3 select 16", periph_in[0], 1'b1);
    map_wr(6'd0, 8'd31); #1;
    chk("R3 select 31", periph_in[0], 1'b1);
    map_wr(6'd0, 8'd15); #1;
    chk("R3 select 15 valid", periph_in[0], 1'b0);
  endtask

  task automatic t_out_map();
    fn_out = 8'h02; fn_oe = 8'h02;
    map_wr(6'd20, 8'd2); #1;
    chk("R4 pin4 out", pin_out[4], 1'b1);
    chk("R4 pin4 oe", pin_oe[4], 1'b1);
    fn_out = 8'h00; #1;
    chk("R4 pin4 follows fn", pin_out[4], 1'b0);
    fn_out = 8'h80; fn_oe = 8'h80;
    map_wr(6'd31, 8'd8); #1;
    chk("R4 pin15 code8 out", pin_out[15], 1'b1);
    chk("R4 pin15 code8 oe", pin_oe[15], 1'b1);
    chk("R4 other pins port", {pin_out[14:5], pin_out[3:0]},
        {PORT_OUT[14:5], PORT_OUT[3:0]});
  endtask

  task automatic t_code_zero();
    map_wr(6'd20, 8'd0); #1;
    chk("R5 code0 out", pin_out[4], PORT_OUT[4]);
    chk("R5 code0 oe", pin_oe[4], PORT_OE[4]);
    fn_out = '1; fn_oe = '1;
    map_wr(6'd20, 8'd9); #1;
    chk("R5 code9 oe", pin_oe[4], PORT_OE[4]);
    fn_out = 8'h80; fn_oe = 8'h80;
  endtask

  task automatic t_analog();
    ana = 16'h8002; #1;
    chk("R6 remapped pin15 out", pin_out[15], 1'b0);
    chk("R6 remapped pin15 oe", pin_oe[15], 1'b0);
    chk("R6 port pin1", {pin_out[1], pin_oe[1]}, 2'b00);
    ana = '0; #1;
    chk("R6 released pin15", {pin_out[15], pin_oe[15]}, 2'b11);
    chk("R6 released pin1", {pin_out[1], pin_oe[1]}, 2'b11);
  endtask

  task automatic t_shared_pin();
    fn_out = 8'h02; fn_oe = 8'h02; pads = '0;
    map_wr(6'd20, 8'd2);
    map_wr(6'd6, 8'd4);
    // write to input 7 set up; value before the taking edge must be old
    unlock();
    bus_valid = 1'b1; bus_addr = 6'd7; bus_wdata = 8'd4;
    #1;
    chk("R10 before edge", periph_in[7], 1'b1);
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; #1;
    chk("R10 after edge", periph_in[7], 1'b0);
    pads = 16'h0010; fn_out = 8'h00; #1;
    chk("R10 both inputs pad4", {periph_in[7], periph_in[6]}, 2'b11);
    chk("R10 pin4 still remapped", {pin_out[4], pin_oe[4]}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_in_route();
    t_one_shot();
    t_bad_key();
    t_invalid();
    t_out_map();
    t_code_zero();
    t_analog();
    t_shared_pin();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule